// File: doc/BRIEF.md
# Lockable Fully-Associative Instruction Cache

This block is an instruction cache built for real-time systems, where the time a fetch takes must be known in advance. Any memory line of 16 bytes can sit in any of its entries. Software first writes lines into chosen entries through a preload port. It then sets the lock. From that point on, the contents of the entries never change. There is no replacement policy and no allocation on a miss.

A fetch whose line matches a valid entry is answered in the same cycle that it is presented. A fetch that matches neither an entry nor the stream buffer asks memory for the whole line. Memory returns the line as four 32-bit beats into a single line-sized buffer, and the fetch completes in the cycle after the fourth beat. Further fetches to that line hit the buffer at hit timing until a miss to another line overwrites the buffer. A miss costs the memory latency plus a fixed overhead, and a hit always costs nothing extra, so a timing analysis can count on both.

Top module: `lock_icache`

## Requirements
- R1: After reset every entry and the stream buffer are invalid, the lock is released, fillReq is low, and the first fetch to any address is a miss.
- R2: A preload write (preloadEn high at a clock edge while unlocked) stores preloadTag and preloadLine into entry preloadIdx. Any index may hold any line. Word w of the line is preloadLine[32w+31:32w], and fetchAddr[3:2] selects w. A later fetch to that line sees fetchReady high in the same cycle as fetchValid, with that word on fetchData.
- R3: A one-cycle pulse on lockSet sets a lock that stays set until reset. While the lock is set, preload writes are ignored, so an entry keeps its old line and a newly offered line is not cached.
- R4: On a fetch that misses both the entries and the buffer, fillReq rises in the next cycle. fillAddr holds the line base (fetch address with bits [3:0] cleared) and stays stable while fillReq is high. The beats fill words 0,1,2,3 in that order, and fillReq falls after the fourth beat.
- R5: During a fill fetchReady stays low. It rises in the cycle after the fourth beat, and fetchData then carries the word selected by fetchAddr[3:2] from the beats.
- R6: After a fill, fetches to the same line hit the buffer in the same cycle. The buffer is invalid while a fill is under way, and a miss to another line replaces its content.
- R7: A miss never writes an entry. Lines preloaded before the lock still return their preloaded data after any number of misses.
- R8: When a line is both in an entry and in the buffer, the entry's data is returned.
- R9: Before the lock, a preload to an occupied index replaces that entry's line, so the old line misses and the new line hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchValid | input | 1 | Fetch request present |
| fetchAddr | input | ADDR_W | Fetch byte address |
| fetchReady | output | 1 | Fetch answered this cycle |
| fetchData | output | 32 | Instruction word |
| preloadEn | input | 1 | Write a line into an entry |
| preloadIdx | input | log2(ENTRIES) | Entry written by a preload |
| preloadTag | input | ADDR_W-4 | Line address of the preloaded line |
| preloadLine | input | 128 | Line contents, word 0 in the low bits |
| lockSet | input | 1 | Pulse that freezes the entries until reset |
| fillReq | output | 1 | Line fill request to memory |
| fillAddr | output | ADDR_W | Base byte address of the line to fill |
| fillBeatValid | input | 1 | A fill beat is present |
| fillBeatData | input | 32 | Fill beat word, in word order |

## Verification
A hit on an entry or on the buffer must show fetchReady high in the same cycle as fetchValid. The bench therefore samples one time unit after the falling edge at which it drives the fetch, and requires zero wait cycles. The bench memory starts beats LAT-1 cycles after it first sees fillReq, so a miss must become ready exactly LAT+4 falling edges after the fetch was driven. Each fetch is checked against that exact count and against the word the bench computes for the line's origin. Preloaded lines carry the inverted memory pattern, so a check can tell an entry from the buffer. Preload and lock writes take effect at the next rising edge, and the fetches that test them start at the falling edge after that.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int WORDS_PER_LINE = 4;
  localparam int LINE_W = 32 * WORDS_PER_LINE;

  typedef enum logic {
    ST_IDLE,
    ST_FILL
  } ctrl_state_e;

  typedef struct packed {
    logic       startFill;
    logic       beatWrite;
    logic [1:0] beatIdx;
    logic       fillDone;
  } dp_strobe_t;
endpackage

// File: rtl/lic_datapath.sv
module lic_datapath #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  localparam int TAG_W  = ADDR_W - 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         fetchAddr,
  input  logic                      preloadEn,
  input  logic [IDX_W-1:0]          preloadIdx,
  input  logic [TAG_W-1:0]          preloadTag,
  input  logic [lic_pkg::LINE_W-1:0] preloadLine,
  input  logic                      lockSet,
  input  logic [31:0]               fillBeatData,
  input  lic_pkg::dp_strobe_t       strb,
  output logic                      cacheHit,
  output logic                      bufHit,
  output logic                      bufValid,
  output logic [ENTRIES-1:0]        entValid,
  output logic                      locked,
  output logic [31:0]               fetchData,
  output logic [ADDR_W-1:0]         fillAddr
);
  import lic_pkg::*;

  logic [TAG_W-1:0]  reqTag;
  logic [1:0]        wordSel;
  logic [1:0]        unusedAddrBits;
  logic              lockQ;
  logic [ENTRIES-1:0] hitVec;
  logic [LINE_W-1:0] entLine [ENTRIES];
  logic [LINE_W-1:0] cacheLine;

  assign reqTag         = fetchAddr[ADDR_W-1:4];
  assign wordSel        = fetchAddr[3:2];
  assign unusedAddrBits = fetchAddr[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lockQ <= 1'b0;
    else if (lockSet) lockQ <= 1'b1;
  end
  assign locked = lockQ;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic              vQ;
    logic [TAG_W-1:0]  tQ;
    logic [LINE_W-1:0] lQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vQ <= 1'b0;
        tQ <= '0;
        lQ <= '0;
      end else if (preloadEn && !lockQ && preloadIdx == IDX_W'(e)) begin
        vQ <= 1'b1;
        tQ <= preloadTag;
        lQ <= preloadLine;
      end
    end
    assign hitVec[e]   = vQ && (tQ == reqTag);
    assign entLine[e]  = lQ;
    assign entValid[e] = vQ;
  end

  always_comb begin
    cacheLine = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hitVec[e]) cacheLine = cacheLine | entLine[e];
    end
  end
  assign cacheHit = |hitVec;

  // one-line stream buffer
  logic             bufValidQ;
  logic [TAG_W-1:0] bufTagQ;
  logic [TAG_W-1:0] missTagQ;
  logic [31:0]      bufWordQ [WORDS_PER_LINE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValidQ <= 1'b0;
      bufTagQ   <= '0;
      missTagQ  <= '0;
      for (int w = 0; w < WORDS_PER_LINE; w++) bufWordQ[w] <= '0;
    end else begin
      if (strb.startFill) begin
        bufValidQ <= 1'b0;
        missTagQ  <= reqTag;
      end
      if (strb.beatWrite) bufWordQ[strb.beatIdx] <= fillBeatData;
      if (strb.fillDone) begin
        bufValidQ <= 1'b1;
        bufTagQ   <= missTagQ;
      end
    end
  end

  assign bufHit    = bufValidQ && (bufTagQ == reqTag);
  assign bufValid  = bufValidQ;
  assign fetchData = cacheHit ? cacheLine[{wordSel, 5'd0} +: 32] : bufWordQ[wordSel];
  assign fillAddr  = {missTagQ, 4'b0000};
endmodule

// File: rtl/lic_ctrl.sv
module lic_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fetchValid,
  input  logic                cacheHit,
  input  logic                bufHit,
  input  logic                fillBeatValid,
  output logic                fetchReady,
  output logic                fillReq,
  output lic_pkg::dp_strobe_t strb
);
  import lic_pkg::*;

  ctrl_state_e stateQ, stateNext;
  logic [1:0]  beatCntQ;

  always_comb begin
    strb         = '0;
    strb.beatIdx = beatCntQ;
    stateNext    = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (fetchValid && !cacheHit && !bufHit) begin
          strb.startFill = 1'b1;
          stateNext      = ST_FILL;
        end
      end
      ST_FILL: begin
        if (fillBeatValid) begin
          strb.beatWrite = 1'b1;
          if (beatCntQ == 2'd3) begin
            strb.fillDone = 1'b1;
            stateNext     = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      beatCntQ <= 2'd0;
    end else begin
      stateQ <= stateNext;
      if (strb.startFill)      beatCntQ <= 2'd0;
      else if (strb.beatWrite) beatCntQ <= beatCntQ + 2'd1;
    end
  end

  assign fetchReady = (stateQ == ST_IDLE) && fetchValid && (cacheHit || bufHit);
  assign fillReq    = (stateQ == ST_FILL);
endmodule

// File: rtl/lock_icache.sv
module lock_icache #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  localparam int TAG_W  = ADDR_W - 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchValid,
  input  logic [ADDR_W-1:0]  fetchAddr,
  output logic               fetchReady,
  output logic [31:0]        fetchData,
  input  logic               preloadEn,
  input  logic [IDX_W-1:0]   preloadIdx,
  input  logic [TAG_W-1:0]   preloadTag,
  input  logic [127:0]       preloadLine,
  input  logic               lockSet,
  output logic               fillReq,
  output logic [ADDR_W-1:0]  fillAddr,
  input  logic               fillBeatValid,
  input  logic [31:0]        fillBeatData
);
  lic_pkg::dp_strobe_t strb;
  logic               cacheHit;
  logic               bufHit;
  logic               bufValid;
  logic [ENTRIES-1:0] entValid;
  logic               locked;

  lic_datapath #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr),
    .preloadEn(preloadEn), .preloadIdx(preloadIdx), .preloadTag(preloadTag),
    .preloadLine(preloadLine), .lockSet(lockSet), .fillBeatData(fillBeatData),
    .strb(strb), .cacheHit(cacheHit), .bufHit(bufHit), .bufValid(bufValid),
    .entValid(entValid), .locked(locked), .fetchData(fetchData), .fillAddr(fillAddr)
  );

  lic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .cacheHit(cacheHit),
    .bufHit(bufHit), .fillBeatValid(fillBeatValid), .fetchReady(fetchReady),
    .fillReq(fillReq), .strb(strb)
  );
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               fetchValid,
  input logic               fetchReady,
  input logic               fillReq,
  input logic [ADDR_W-1:0]  fillAddr,
  input logic               fillBeatValid,
  input logic               cacheHit,
  input logic               bufValid,
  input logic [ENTRIES-1:0] entValid,
  input logic               locked
);
  logic [2:0] beatSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              beatSeen <= 3'd0;
    else if (!fillReq)      beatSeen <= 3'd0;
    else if (fillBeatValid) beatSeen <= beatSeen + 3'd1;
  end

  // R2
  hit_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && cacheHit && !fillReq |-> fetchReady);
  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);
  // R3
  frozen_entries_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(entValid));
  // R4
  fill_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillReq && $past(fillReq) |-> $stable(fillAddr));
  // R4
  fill_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillReq && fillBeatValid && beatSeen == 3'd3 |=> !fillReq);
  // R4
  fill_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> fillAddr[3:0] == 4'd0);
  // R5
  fill_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> !fetchReady);
  // R6
  buf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> !bufValid);
endmodule

bind lock_icache lic_checker #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) chk (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchReady(fetchReady),
  .fillReq(fillReq), .fillAddr(fillAddr), .fillBeatValid(fillBeatValid),
  .cacheHit(cacheHit), .bufValid(bufValid), .entValid(entValid), .locked(locked)
);

// File: tb/lock_icache_test.sv
`timescale 1ns/1ps
module lock_icache_test;
  localparam int ADDR_W = 32;
  localparam int ENTRIES = 8;
  localparam int TAG_W = ADDR_W - 4;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int LAT = 2;
  localparam int MISS_WAIT = LAT + 4;

  logic clk = 1'b0;
  logic rstN;
  logic fetchValid;
  logic [ADDR_W-1:0] fetchAddr;
  logic fetchReady;
  logic [31:0] fetchData;
  logic preloadEn;
  logic [IDX_W-1:0] preloadIdx;
  logic [TAG_W-1:0] preloadTag;
  logic [127:0] preloadLine;
  logic lockSet;
  logic fillReq;
  logic [ADDR_W-1:0] fillAddr;
  logic fillBeatValid;
  logic [31:0] fillBeatData;

  always #2 clk = ~clk;

  lock_icache #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) uut (.*);

  int total = 0;
  int bad = 0;
  logic [ADDR_W-1:0] lastFillAddr = '0;

  // bench model
  logic [TAG_W-1:0] mTag [ENTRIES];
  bit               mValid [ENTRIES];
  bit               mLocked;
  bit               mBufValid;
  logic [TAG_W-1:0] mBufTag;

  function automatic logic [31:0] memWord(input logic [ADDR_W-1:0] a);
    return (a[31:2] * 32'h9E3779B1) ^ 32'h5A3C_0F12;
  endfunction

  function automatic logic [127:0] cachedLine(input logic [TAG_W-1:0] t);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[32*w +: 32] = ~memWord({t, 2'(w), 2'b00});
    return l;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int e = 0; e < ENTRIES; e++) begin mValid[e] = 0; mTag[e] = '0; end
    mLocked = 0;
    mBufValid = 0;
    mBufTag = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    fetchValid = 1'b0;
    preloadEn = 1'b0;
    lockSet = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic preload(input int idx, input logic [TAG_W-1:0] t);
    @(negedge clk);
    fetchValid = 1'b0;
    preloadEn = 1'b1;
    preloadIdx = IDX_W'(idx);
    preloadTag = t;
    preloadLine = cachedLine(t);
    @(negedge clk);
    preloadEn = 1'b0;
    if (!mLocked) begin mValid[idx] = 1; mTag[idx] = t; end
  endtask

  task automatic lockIt();
    @(negedge clk);
    fetchValid = 1'b0;
    lockSet = 1'b1;
    @(negedge clk);
    lockSet = 1'b0;
    mLocked = 1;
  endtask

  task automatic fetchChk(input logic [TAG_W-1:0] t, input logic [1:0] w, input string req);
    logic [ADDR_W-1:0] a;
    logic [31:0] expData;
    int expWait;
    int waitCyc;
    bit inCache;
    a = {t, w, 2'b00};
    inCache = 0;
    for (int e = 0; e < ENTRIES; e++) if (mValid[e] && mTag[e] == t) inCache = 1;
    if (inCache) begin
      expWait = 0; expData = ~memWord(a);
    end else if (mBufValid && mBufTag == t) begin
      expWait = 0; expData = memWord(a);
    end else begin
      expWait = MISS_WAIT; expData = memWord(a);
    end
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr = a;
    waitCyc = 0;
    #1;
    while (!fetchReady && waitCyc < 100) begin
      @(negedge clk);
      #1;
      waitCyc++;
    end
    check(waitCyc == expWait, req, "wait cycles", 64'(waitCyc), 64'(expWait));
    check(fetchData == expData, req, "fetch data", 64'(fetchData), 64'(expData));
    if (expWait != 0) begin
      check(lastFillAddr == {t, 4'b0000}, "R4", "fill address",
            64'(lastFillAddr), 64'({t, 4'b0000}));
      mBufValid = 1;
      mBufTag = t;
    end
    @(posedge clk);
  endtask

  // memory model: beats start LAT-1 cycles after fillReq is seen
  initial begin
    fillBeatValid = 1'b0;
    fillBeatData = '0;
    forever begin
      @(negedge clk);
      if (fillReq) begin
        lastFillAddr = fillAddr;
        repeat (LAT - 1) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          fillBeatValid = 1'b1;
          fillBeatData = memWord(lastFillAddr + ADDR_W'(4 * b));
          @(negedge clk);
        end
        fillBeatValid = 1'b0;
      end
    end
  end

  initial begin
    #(100000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [TAG_W-1:0] TAG_A = 28'h200, TAG_B = 28'h201, TAG_C = 28'h202;
  localparam logic [TAG_W-1:0] TAG_D = 28'h203, TAG_E = 28'h204;
  localparam logic [TAG_W-1:0] TAG_F = 28'h300, TAG_G = 28'h301, TAG_P = 28'h010;

  initial begin
    logic [TAG_W-1:0] pool [12];
    fetchAddr = '0;
    preloadIdx = '0;
    preloadTag = '0;
    preloadLine = '0;
    doReset();

    // R1: quiet after reset
    #1;
    check(fillReq == 1'b0, "R1", "fillReq after reset", 64'(fillReq), 64'd0);
    check(fetchReady == 1'b0, "R1", "fetchReady idle", 64'(fetchReady), 64'd0);
    fetchChk(TAG_P, 2'd0, "R1");           // first fetch misses
    fetchChk(TAG_P, 2'd2, "R6");           // buffer hit
    fetchChk(TAG_P, 2'd1, "R5");

    // R8: entry beats buffer
    preload(5, TAG_P);
    fetchChk(TAG_P, 2'd3, "R8");

    // R2: any index, all words
    preload(0, TAG_A);
    preload(7, TAG_B);
    for (int w = 0; w < 4; w++) fetchChk(TAG_A, 2'(w), "R2");
    for (int w = 0; w < 4; w++) fetchChk(TAG_B, 2'(w), "R2");

    // R9: overwrite before lock
    preload(0, TAG_C);
    fetchChk(TAG_A, 2'd1, "R9");
    fetchChk(TAG_C, 2'd2, "R9");

    // R3: lock freezes entries
    lockIt();
    preload(1, TAG_D);
    fetchChk(TAG_D, 2'd0, "R3");
    preload(0, TAG_E);
    fetchChk(TAG_C, 2'd0, "R3");
    fetchChk(TAG_E, 2'd3, "R3");

    // R6/R7: buffer replacement, entries untouched
    fetchChk(TAG_F, 2'd0, "R4");
    fetchChk(TAG_F, 2'd3, "R6");
    fetchChk(TAG_G, 2'd1, "R6");
    fetchChk(TAG_F, 2'd2, "R6");
    fetchChk(TAG_C, 2'd3, "R7");
    fetchChk(TAG_B, 2'd1, "R7");

    // constrained random fetches over a small pool of lines
    pool[0] = TAG_C; pool[1] = TAG_B; pool[2] = TAG_P;
    for (int k = 3; k < 12; k++) pool[k] = 28'h400 + 28'(k);
    void'($urandom(32'd20240613));
    for (int n = 0; n < 300; n++) begin
      int k;
      k = int'($urandom % 12);
      fetchChk(pool[k], 2'($urandom % 4), "R7");
    end

    // R3: reset releases the lock
    doReset();
    preload(2, TAG_D);
    fetchChk(TAG_D, 2'd2, "R3");
    fetchChk(TAG_C, 2'd0, "R1");

    @(negedge clk);
    fetchValid = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule